// File: doc/BRIEF.md
# Platform System Control Port Block

This block is a byte-wide register file on a synchronous I/O bus. It stands for the system control ports of a small workstation board. One lone port controls a soft-reset level and a byte-order mode flag. A window of ports higher up returns fixed board identification and equipment codes. The same window holds a disk-activity lamp bit, a four-bit system control field and an I/O map mode bit. It also fires single-cycle toggle pulses toward an external lock circuit.

Every control bit is held in a register and driven out as a level. The consumers are the CPU reset logic, the byte-swap path, the lamp driver and the bus bridge. Address, write data and the read and write strobes are sampled on the rising clock edge. Read data arrives on the next cycle, marked by a one-cycle valid flag. A write to an address that has no write behaviour raises a one-cycle error flag.

Top module: `sysctl_regfile`

## Requirements
- R1: A write to address 0x092 drives `cpu_reset_o` to write-data bit 0 and stores write-data bit 1 as the byte-order flag on `le_mode_o`. Both change in the cycle after the write strobe is sampled.
- R2: A read of 0x092 returns the byte-order flag in bit 1, with all other bits zero. The reset level is never returned.
- R3: Reads of 0x800, 0x802 and 0x803 return 0xEF, 0xAD and 0xE0. Writes to those three addresses change no output and raise no error.
- R4: Reads of 0x80C, 0x810, 0x818 and 0x823 return 0x3C, 0x39, 0x00 and 0x03.
- R5: A write to 0x808 sets `led_o` when write-data bit 0 is 1 and clears it otherwise. `led_o` changes on no other write.
- R6: A write to 0x810 pulses `lock1_o` high for exactly one cycle. A write to 0x812 does the same on `lock2_o`.
- R7: A write to 0x81C stores write-data bits 3:0 on `sysctl_o`. A read of 0x81C returns those bits with bits 7:4 zero.
- R8: A write to 0x850 stores write-data bit 0 on `map_mode_o`. A read of 0x850 returns it in bit 0, with the other bits zero.
- R9: A read of any address without a defined value returns 0xFF. This covers 0x814, 0x808, 0x812, addresses inside 0x800..0x851 that are not listed, and addresses outside the block. A write to 0x814 changes no output and raises no error.
- R10: `bus_rvalid` is high for exactly the cycle after a sampled read strobe, and `bus_rdata` holds the result in that cycle.
- R11: While `rst` is high at a clock edge, every control output, pulse and flag is cleared, including `cpu_reset_o`.
- R12: A write to an address with no write behaviour raises `wr_err_o` for one cycle. That covers 0x80C, 0x818, 0x823, unlisted window addresses and addresses outside the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Port address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| cpu_reset_o | output | 1 | Soft reset level toward the CPU |
| le_mode_o | output | 1 | Byte-order mode flag |
| led_o | output | 1 | Disk-activity lamp |
| sysctl_o | output | 4 | System control field |
| map_mode_o | output | 1 | I/O map mode |
| lock1_o | output | 1 | Lock toggle pulse, channel 1 |
| lock2_o | output | 1 | Lock toggle pulse, channel 2 |
| wr_err_o | output | 1 | Write to an address without a write handler |

## Verification
The special port is written with all four combinations of its two low data bits. This separates the live reset level from the stored byte-order bit and shows that only the stored bit reads back.

The control nibble is written with bytes whose upper nibbles are non-zero, which exposes any leak of the high bits. The lamp and map bits are written with 0xFF and 0xFE, so that only bit 0 decides the result. Reads sweep every constant address, the neighbours of each handled address and addresses outside the block, which tells decoded constants apart from the all-ones default.

Writes to the read-only, ignored and unhandled addresses are followed by checks of every output and of the error flag. These checks separate "no effect" from "error".

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
package sysctl_pkg;

  localparam int unsigned PA_W = 12;

  // Port addresses; the decode depends on these exact values.
  localparam logic [PA_W-1:0] A_SPECIAL = 12'h092;
  localparam logic [PA_W-1:0] A_CPUCFG  = 12'h800;
  localparam logic [PA_W-1:0] A_FEAT    = 12'h802;
  localparam logic [PA_W-1:0] A_STAT    = 12'h803;
  localparam logic [PA_W-1:0] A_LAMP    = 12'h808;
  localparam logic [PA_W-1:0] A_EQUIP   = 12'h80C;
  localparam logic [PA_W-1:0] A_LOCK1   = 12'h810;
  localparam logic [PA_W-1:0] A_LOCK2   = 12'h812;
  localparam logic [PA_W-1:0] A_CINV    = 12'h814;
  localparam logic [PA_W-1:0] A_KEY     = 12'h818;
  localparam logic [PA_W-1:0] A_CTRL    = 12'h81C;
  localparam logic [PA_W-1:0] A_CSTAT   = 12'h823;
  localparam logic [PA_W-1:0] A_MAP     = 12'h850;
  localparam logic [PA_W-1:0] A_WIN_LO  = 12'h800;
  localparam logic [PA_W-1:0] A_WIN_HI  = 12'h851;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_SPECIAL,
    SEL_CPUCFG,
    SEL_FEAT,
    SEL_STAT,
    SEL_LAMP,
    SEL_EQUIP,
    SEL_LOCK1,
    SEL_LOCK2,
    SEL_CINV,
    SEL_KEY,
    SEL_CTRL,
    SEL_CSTAT,
    SEL_MAP,
    SEL_WINGAP
  } sel_e;

  // Fixed read codes; all-ones means "no defined value".
  function automatic logic [7:0] fixed_code(input sel_e s);
    case (s)
      SEL_CPUCFG: fixed_code = 8'hEF;
      SEL_FEAT:   fixed_code = 8'hAD;
      SEL_STAT:   fixed_code = 8'hE0;
      SEL_EQUIP:  fixed_code = 8'h3C;
      SEL_LOCK1:  fixed_code = 8'h39;
      SEL_KEY:    fixed_code = 8'h00;
      SEL_CSTAT:  fixed_code = 8'h03;
      default:    fixed_code = 8'hFF;
    endcase
  endfunction

  // Selections that take a write (with or without effect).
  function automatic logic has_wr_handler(input sel_e s);
    case (s)
      SEL_SPECIAL, SEL_CPUCFG, SEL_FEAT, SEL_STAT, SEL_LAMP,
      SEL_LOCK1, SEL_LOCK2, SEL_CINV, SEL_CTRL, SEL_MAP:
        has_wr_handler = 1'b1;
      default:
        has_wr_handler = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
`timescale 1ns/1ps
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel
);

  logic in_window;

  assign in_window = (addr >= ADDR_W'(A_WIN_LO)) && (addr <= ADDR_W'(A_WIN_HI));

  always_comb begin
    sel = SEL_NONE;
    if (addr == ADDR_W'(A_SPECIAL)) begin
      sel = SEL_SPECIAL;
    end else if (in_window) begin
      sel = SEL_WINGAP;
      case (addr)
        ADDR_W'(A_CPUCFG): sel = SEL_CPUCFG;
        ADDR_W'(A_FEAT):   sel = SEL_FEAT;
        ADDR_W'(A_STAT):   sel = SEL_STAT;
        ADDR_W'(A_LAMP):   sel = SEL_LAMP;
        ADDR_W'(A_EQUIP):  sel = SEL_EQUIP;
        ADDR_W'(A_LOCK1):  sel = SEL_LOCK1;
        ADDR_W'(A_LOCK2):  sel = SEL_LOCK2;
        ADDR_W'(A_CINV):   sel = SEL_CINV;
        ADDR_W'(A_KEY):    sel = SEL_KEY;
        ADDR_W'(A_CTRL):   sel = SEL_CTRL;
        ADDR_W'(A_CSTAT):  sel = SEL_CSTAT;
        ADDR_W'(A_MAP):    sel = SEL_MAP;
        default:           sel = SEL_WINGAP;
      endcase
    end
  end

endmodule

// File: rtl/sysctl_store.sv
`timescale 1ns/1ps
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  sel_e              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic              cpu_reset,
  output logic              le_mode,
  output logic              led,
  output logic [CTRL_W-1:0] ctrl,
  output logic              map_mode,
  output logic              lock1,
  output logic              lock2,
  output logic              wr_err
);

  logic unused_hi;
  assign unused_hi = ^wdata[DATA_W-1:CTRL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_reset <= 1'b0;
      le_mode   <= 1'b0;
      led       <= 1'b0;
      ctrl      <= '0;
      map_mode  <= 1'b0;
      lock1     <= 1'b0;
      lock2     <= 1'b0;
      wr_err    <= 1'b0;
    end else begin
      lock1  <= 1'b0;
      lock2  <= 1'b0;
      wr_err <= wr_en && !has_wr_handler(sel);
      if (wr_en) begin
        case (sel)
          SEL_SPECIAL: begin
            cpu_reset <= wdata[0];
            le_mode   <= wdata[1];
          end
          SEL_LAMP:  led      <= wdata[0];
          SEL_LOCK1: lock1    <= 1'b1;
          SEL_LOCK2: lock2    <= 1'b1;
          SEL_CTRL:  ctrl     <= wdata[CTRL_W-1:0];
          SEL_MAP:   map_mode <= wdata[0];
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/sysctl_rdmux.sv
`timescale 1ns/1ps
module sysctl_rdmux
  import sysctl_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  sel_e              sel,
  input  logic              le_mode,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              map_mode,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    case (sel)
      SEL_SPECIAL: rd_next = DATA_W'({le_mode, 1'b0});
      SEL_CTRL:    rd_next = DATA_W'(ctrl);
      SEL_MAP:     rd_next = DATA_W'(map_mode);
      SEL_NONE, SEL_WINGAP, SEL_LAMP, SEL_LOCK2, SEL_CINV:
                   rd_next = '1;
      default:     rd_next = DATA_W'(fixed_code(sel));
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_next;
    end
  end

endmodule

// File: rtl/sysctl_regfile.sv
`timescale 1ns/1ps
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              cpu_reset_o,
  output logic              le_mode_o,
  output logic              led_o,
  output logic [CTRL_W-1:0] sysctl_o,
  output logic              map_mode_o,
  output logic              lock1_o,
  output logic              lock2_o,
  output logic              wr_err_o
);

  sel_e sel;

  sysctl_decode #(.ADDR_W(ADDR_W)) decode_i (
    .addr (bus_addr),
    .sel  (sel)
  );

  sysctl_store #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) store_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bus_wr),
    .sel       (sel),
    .wdata     (bus_wdata),
    .cpu_reset (cpu_reset_o),
    .le_mode   (le_mode_o),
    .led       (led_o),
    .ctrl      (sysctl_o),
    .map_mode  (map_mode_o),
    .lock1     (lock1_o),
    .lock2     (lock2_o),
    .wr_err    (wr_err_o)
  );

  sysctl_rdmux #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) rdmux_i (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (bus_rd),
    .sel      (sel),
    .le_mode  (le_mode_o),
    .ctrl     (sysctl_o),
    .map_mode (map_mode_o),
    .rdata    (bus_rdata),
    .rvalid   (bus_rvalid)
  );

endmodule

// File: rtl/sysctl_chk.sv
`timescale 1ns/1ps
module sysctl_chk
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CTRL_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic              cpu_reset_o,
  input logic              led_o,
  input logic              lock1_o,
  input logic              lock2_o,
  input logic              wr_err_o
);

  AST_RESET_LEVEL: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_wr && bus_addr == ADDR_W'(A_SPECIAL)) && !$past(rst)) |-> (cpu_reset_o == $past(bus_wdata[0]))); // R1

  AST_SPECIAL_RD: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_rd && bus_addr == ADDR_W'(A_SPECIAL)) && !$past(rst)) |-> ((bus_rdata & ~DATA_W'(2)) == '0)); // R2

  AST_LAMP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(bus_wr) && !$past(rst)) |-> $stable(led_o)); // R5

  AST_LOCK1_SRC: assert property (@(posedge clk) disable iff (rst)
    lock1_o |-> $past(bus_wr && bus_addr == ADDR_W'(A_LOCK1))); // R6

  AST_LOCK2_SRC: assert property (@(posedge clk) disable iff (rst)
    lock2_o |-> $past(bus_wr && bus_addr == ADDR_W'(A_LOCK2))); // R6

  AST_CTRL_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_rd && bus_addr == ADDR_W'(A_CTRL)) && !$past(rst)) |-> (bus_rdata[DATA_W-1:CTRL_W] == '0)); // R7

  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid); // R10

  AST_RVALID_SRC: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_rd)); // R10

  AST_ERR_SRC: assert property (@(posedge clk) disable iff (rst)
    wr_err_o |-> $past(bus_wr)); // R12

endmodule

bind sysctl_regfile sysctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rd      (bus_rd),
  .bus_wr      (bus_wr),
  .bus_rdata   (bus_rdata),
  .bus_rvalid  (bus_rvalid),
  .cpu_reset_o (cpu_reset_o),
  .led_o       (led_o),
  .lock1_o     (lock1_o),
  .lock2_o     (lock2_o),
  .wr_err_o    (wr_err_o)
);

// File: tb/sysctl_regfile_tb_top.sv
`timescale 1ns/1ps
module sysctl_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_rdata;
  logic        bus_rvalid;
  logic        cpu_reset_o, le_mode_o, led_o, map_mode_o;
  logic [3:0]  sysctl_o;
  logic        lock1_o, lock2_o, wr_err_o;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  sysctl_regfile dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .cpu_reset_o(cpu_reset_o), .le_mode_o(le_mode_o),
    .led_o(led_o), .sysctl_o(sysctl_o), .map_mode_o(map_mode_o),
    .lock1_o(lock1_o), .lock2_o(lock2_o), .wr_err_o(wr_err_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Packed view of every level/pulse output: {rst,le,led,ctrl[3:0],map,l1,l2,err}
  function automatic logic [10:0] outs();
    return {cpu_reset_o, le_mode_o, led_o, sysctl_o, map_mode_o, lock1_o, lock2_o, wr_err_o};
  endfunction

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back('{val: e, tag: tag});
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Monitor: R10 timing, data compared in the cycle after the strobe
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        chk("R10 unexpected rvalid", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, bus_rdata, e.val);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [10:0] snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R11 outputs after reset", outs(), 11'h0);
    chk("R11 rvalid after reset", bus_rvalid, 0);

    rd(12'h092, 8'h00, "R11 special reads zero");
    rd(12'h81C, 8'h00, "R11 ctrl reads zero");
    rd(12'h850, 8'h00, "R11 map reads zero");

    // constants
    rd(12'h800, 8'hEF, "R3 cpu config");
    rd(12'h802, 8'hAD, "R3 feature");
    rd(12'h803, 8'hE0, "R3 status");
    rd(12'h80C, 8'h3C, "R4 equipment");
    rd(12'h810, 8'h39, "R4 ext feature");
    rd(12'h818, 8'h00, "R4 keylock");
    rd(12'h823, 8'h03, "R4 cache status");
    // all-ones default
    rd(12'h814, 8'hFF, "R9 0x814");
    rd(12'h808, 8'hFF, "R9 0x808");
    rd(12'h812, 8'hFF, "R9 0x812");
    rd(12'h801, 8'hFF, "R9 0x801");
    rd(12'h851, 8'hFF, "R9 0x851");
    rd(12'h000, 8'hFF, "R9 outside");
    rd(12'h7FF, 8'hFF, "R9 below window");
    rd(12'h093, 8'hFF, "R9 next to special");

    // R10 back-to-back reads
    @(negedge clk);
    bus_addr = 12'h800; bus_rd = 1'b1; exp_q.push_back('{val: 8'hEF, tag: "R10 b2b first"});
    @(negedge clk);
    bus_addr = 12'h802; exp_q.push_back('{val: 8'hAD, tag: "R10 b2b second"});
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
    chk("R10 rvalid drops", bus_rvalid, 0);

    // R1 / R2 special port, all four bit patterns
    wr(12'h092, 8'h03);
    chk("R1 reset level 1", cpu_reset_o, 1); chk("R1 endian 1", le_mode_o, 1);
    rd(12'h092, 8'h02, "R2 endian read 1");
    wr(12'h092, 8'hFE);
    chk("R1 reset level 0", cpu_reset_o, 0); chk("R1 endian kept", le_mode_o, 1);
    rd(12'h092, 8'h02, "R2 reset hidden");
    wr(12'h092, 8'h01);
    chk("R1 reset 1 endian 0", {cpu_reset_o, le_mode_o}, 2'b10);
    rd(12'h092, 8'h00, "R2 reset bit not returned");
    wr(12'h092, 8'h00);
    chk("R1 both clear", {cpu_reset_o, le_mode_o}, 2'b00);

    // R5 lamp
    wr(12'h808, 8'hFF); chk("R5 lamp set", led_o, 1);
    wr(12'h808, 8'hFE); chk("R5 lamp clear", led_o, 0);
    wr(12'h808, 8'h01); chk("R5 lamp set again", led_o, 1);

    // R7 ctrl nibble
    wr(12'h81C, 8'hA7); chk("R7 ctrl out", sysctl_o, 4'h7);
    rd(12'h81C, 8'h07, "R7 ctrl read");
    wr(12'h81C, 8'h5C); chk("R7 ctrl out 2", sysctl_o, 4'hC);
    rd(12'h81C, 8'h0C, "R7 ctrl read 2");

    // R8 map
    wr(12'h850, 8'hFF); chk("R8 map set", map_mode_o, 1);
    rd(12'h850, 8'h01, "R8 map read");
    wr(12'h850, 8'hFE); chk("R8 map clear", map_mode_o, 0);
    rd(12'h850, 8'h00, "R8 map read 0");
    wr(12'h850, 8'h01);

    // R6 lock pulses
    wr(12'h810, 8'h00);
    chk("R6 lock1 pulse", {lock1_o, lock2_o}, 2'b10);
    @(negedge clk); chk("R6 lock1 one cycle", {lock1_o, lock2_o}, 2'b00);
    wr(12'h812, 8'hFF);
    chk("R6 lock2 pulse", {lock1_o, lock2_o}, 2'b01);
    @(negedge clk); chk("R6 lock2 one cycle", {lock1_o, lock2_o}, 2'b00);

    // R3 / R9 writes without effect and without error
    snap = outs();
    wr(12'h800, 8'h55); chk("R3 write 0x800 no effect", outs(), snap);
    wr(12'h802, 8'h00); chk("R3 write 0x802 no effect", outs(), snap);
    wr(12'h803, 8'hFF); chk("R3 write 0x803 no effect", outs(), snap);
    rd(12'h800, 8'hEF, "R3 constant after write");
    wr(12'h814, 8'hFF); chk("R9 write 0x814 no effect", outs(), snap);
    rd(12'h814, 8'hFF, "R9 0x814 after write");

    // R12 error flag
    wr(12'h80C, 8'h00); chk("R12 err on 0x80C", outs(), snap | 11'h1);
    @(negedge clk); chk("R12 err one cycle", wr_err_o, 0);
    wr(12'h818, 8'h00); chk("R12 err on 0x818", wr_err_o, 1);
    wr(12'h823, 8'h00); chk("R12 err on 0x823", wr_err_o, 1);
    wr(12'h000, 8'h0F); chk("R12 err outside", outs(), snap | 11'h1);
    wr(12'h851, 8'h01); chk("R12 err window gap", wr_err_o, 1);
    wr(12'h808, 8'h01); chk("R12 no err on lamp", wr_err_o, 0);

    // R11 reset mid-run
    wr(12'h092, 8'h03);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R11 reset clears outputs", outs(), 11'h0);
    rd(12'h092, 8'h00, "R11 special after reset");

    repeat (3) @(negedge clk);
    chk("R10 all reads answered", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule